// File: doc/BRIEF.md
# L2 Sharer Directory Controller

This block holds directory state at a shared L2 for eight private L1 data caches. The L1 caches are write-through, so the protocol has no ownership and no dirty states. For each L2 line it tracks, the block keeps an eight-bit sharer mask. Bit `c` of the mask is set when core `c` holds a copy of the line. The only coherence action the block ever produces is an invalidation sent to one core for one line.

Requests arrive one at a time on a valid/ready port, and each carries an operation, a core index and a line address.

- A load fill sets the requester's bit, and allocates a new entry with an empty mask when the line is not yet tracked.
- A store never sets a bit. It invalidates every other sharer and leaves the storing core's own bit as it was.
- An L2 eviction invalidates every recorded sharer and frees the entry, so each L1 stays a subset of the L2.
- When the table is full, a load miss takes a victim entry in rotation. It first back-invalidates the victim's sharers, which amounts to an eviction of the victim line.

Control is a two-state machine. In `ST_IDLE` the port is ready. An accepted request whose invalidation set is non-empty moves the machine to `ST_DRAIN`. `ST_DRAIN` issues one invalidation per cycle, lowest core index first. It stays in `ST_DRAIN` while more than one target remains, and returns to `ST_IDLE` in the cycle that issues the last target. An accepted request with an empty invalidation set leaves the machine in `ST_IDLE`.

Top module: `sdir_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `busy` and `inv_valid` are 0, and no line is tracked: an eviction of any line reports `rsp_hit`=0 and sends no invalidation.
- R2: One cycle after a request is accepted, `rsp_valid` is 1 for exactly one cycle. `rsp_hit` is 1 only if the line was tracked before the request. A load miss allocates an entry whose mask holds only the requester's bit, and a load hit adds the requester's bit.
- R3: A store never sets the requester's bit. A store to an untracked line creates no entry, so a later load to that line reports `rsp_hit`=0.
- R4: A store to a tracked line invalidates every sharer except the storing core, clears those bits, and leaves the storing core's bit unchanged.
- R5: An eviction of a tracked line invalidates every sharer and frees the entry, so a second eviction of that line reports `rsp_hit`=0.
- R6: Invalidations start in the cycle after acceptance. There is one per cycle, in ascending core index, each carrying the affected line on `inv_addr`.
- R7: `busy` is 1 exactly while invalidations remain to be sent, and `req_ready` is 0 during that time. A request presented while `req_ready` is 0 is held, not accepted, and produces no response until it is accepted.
- R8: A request that produces no invalidation leaves `busy` at 0 and `req_ready` at 1 in the following cycle.
- R9: The table has `NUM_ENTRIES` (default 4) entries and fills the lowest free entry first. With the table full, a load miss replaces entries in rotation starting at entry 0. It back-invalidates the victim's sharers with the victim's line address, reports `rsp_hit`=0, and the victim line is no longer tracked afterwards.
- R10: `req_op` encoding is 2'b00 load, 2'b01 store and 2'b10 evict. The value 2'b11 is accepted and answered with `rsp_hit`=0, and it changes no sharer mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | Operation: 00 load, 01 store, 10 evict, 11 none |
| req_core | input | $clog2(NUM_CORES) | Requesting core index |
| req_addr | input | LINE_AW | Line address |
| rsp_valid | output | 1 | One-cycle response for the accepted request |
| rsp_hit | output | 1 | The line was tracked when the request was accepted |
| inv_valid | output | 1 | An invalidation is sent this cycle |
| inv_core | output | $clog2(NUM_CORES) | Core to invalidate |
| inv_addr | output | LINE_AW | Line to invalidate |
| busy | output | 1 | Invalidations still pending |

## Verification
Loads from several cores to one line, followed by an eviction, show both that sharer bits accumulate and that they drain in ascending order. A store is tried in three cases:

- by a sharer among other sharers, which shows that only the other cores are invalidated;
- to an untracked line, which shows that no entry is created;
- by a core that is not a sharer, which shows that its bit is not set.

An eight-sharer eviction with a second request held at the port shows that the back-pressure holds for the full drain. Filling the table and then loading two new lines shows the rotation of victims and the victim address carried on the invalidations.

// File: rtl/sdir_pkg.sv
package sdir_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_EVICT = 2'b10,
        OP_NONE  = 2'b11
    } dir_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } dir_state_e;

endpackage

// File: rtl/sdir_pick.sv
module sdir_pick #(
    parameter int NC = 8,
    localparam int IW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic [NC-1:0] vec,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [NC-1:0] onehot
);
    always_comb begin
        idx = '0;
        for (int i = NC - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any    = |vec;
        onehot = any ? (NC'(1) << idx) : '0;
    end
endmodule

// File: rtl/sdir_table.sv
module sdir_table #(
    parameter int N  = 4,
    parameter int AW = 26,
    parameter int NC = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [IW-1:0] lk_idx,
    output logic [NC-1:0] lk_vec,
    output logic          free_any,
    output logic [IW-1:0] free_idx,
    output logic [IW-1:0] rep_idx,
    output logic [AW-1:0] rep_addr,
    output logic [NC-1:0] rep_vec,
    input  logic          rep_adv,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [NC-1:0] wr_vec
);
    logic [N-1:0]  valid_q;
    logic [AW-1:0] addr_q [N];
    logic [NC-1:0] vec_q  [N];
    logic [N-1:0]  match;
    logic [IW-1:0] rep_q;

    for (genvar g = 0; g < N; g++) begin : g_entry
        assign match[g] = valid_q[g] && (addr_q[g] == lk_addr);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                addr_q[g]  <= '0;
                vec_q[g]   <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                valid_q[g] <= wr_valid;
                addr_q[g]  <= wr_addr;
                vec_q[g]   <= wr_vec;
            end
        end
    end

    always_comb begin
        lk_idx   = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i])    lk_idx   = IW'(i);
            if (!valid_q[i]) free_idx = IW'(i);
        end
        lk_hit   = |match;
        lk_vec   = vec_q[lk_idx];
        free_any = ~&valid_q;
        rep_idx  = rep_q;
        rep_addr = addr_q[rep_q];
        rep_vec  = vec_q[rep_q];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else if (rep_adv) begin
            rep_q <= (rep_q == IW'(N - 1)) ? '0 : rep_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdir_ctrl.sv
module sdir_ctrl
    import sdir_pkg::*;
#(
    parameter int NUM_CORES   = 8,
    parameter int NUM_ENTRIES = 4,
    parameter int LINE_AW     = 26
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [$clog2(NUM_CORES)-1:0] req_core,
    input  logic [LINE_AW-1:0]           req_addr,
    output logic                         rsp_valid,
    output logic                         rsp_hit,
    output logic                         inv_valid,
    output logic [$clog2(NUM_CORES)-1:0] inv_core,
    output logic [LINE_AW-1:0]           inv_addr,
    output logic                         busy
);
    localparam int CW = $clog2(NUM_CORES);
    localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    dir_state_e           state_q, state_d;
    logic [NUM_CORES-1:0] pend_q, pend_d;
    logic [LINE_AW-1:0]   paddr_q, paddr_d;
    logic                 rsp_valid_q, rsp_hit_q;

    logic                 lk_hit, free_any, rep_adv;
    logic [EW-1:0]        lk_idx, free_idx, rep_idx;
    logic [NUM_CORES-1:0] lk_vec, rep_vec;
    logic [LINE_AW-1:0]   rep_addr;
    logic                 wr_en, wr_valid;
    logic [EW-1:0]        wr_idx;
    logic [LINE_AW-1:0]   wr_addr;
    logic [NUM_CORES-1:0] wr_vec;

    logic                 pk_any;
    logic [CW-1:0]        pk_idx;
    logic [NUM_CORES-1:0] pk_onehot;

    logic                 accept;
    dir_op_e              op;
    logic [NUM_CORES-1:0] self_bit;
    logic [NUM_CORES-1:0] new_mask;
    logic [LINE_AW-1:0]   new_addr;

    sdir_table #(
        .N (NUM_ENTRIES),
        .AW(LINE_AW),
        .NC(NUM_CORES)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_addr (req_addr),
        .lk_hit  (lk_hit),
        .lk_idx  (lk_idx),
        .lk_vec  (lk_vec),
        .free_any(free_any),
        .free_idx(free_idx),
        .rep_idx (rep_idx),
        .rep_addr(rep_addr),
        .rep_vec (rep_vec),
        .rep_adv (rep_adv),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_vec  (wr_vec)
    );

    sdir_pick #(.NC(NUM_CORES)) u_pick (
        .vec   (pend_q),
        .any   (pk_any),
        .idx   (pk_idx),
        .onehot(pk_onehot)
    );

    assign op       = dir_op_e'(req_op);
    assign self_bit = NUM_CORES'(1) << req_core;
    assign accept   = req_valid && req_ready;

    // Directory update and invalidation set for the request on the port.
    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = lk_idx;
        wr_valid = 1'b1;
        wr_addr  = req_addr;
        wr_vec   = '0;
        rep_adv  = 1'b0;
        new_mask = '0;
        new_addr = req_addr;
        unique case (op)
            OP_LOAD: begin
                wr_en = accept;
                if (lk_hit) begin
                    wr_vec = lk_vec | self_bit;
                end else if (free_any) begin
                    wr_idx = free_idx;
                    wr_vec = self_bit;
                end else begin
                    wr_idx   = rep_idx;
                    wr_vec   = self_bit;
                    rep_adv  = accept;
                    new_mask = rep_vec;
                    new_addr = rep_addr;
                end
            end
            OP_STORE: begin
                if (lk_hit) begin
                    wr_en    = accept;
                    wr_vec   = lk_vec & self_bit;
                    new_mask = lk_vec & ~self_bit;
                end
            end
            OP_EVICT: begin
                if (lk_hit) begin
                    wr_en    = accept;
                    wr_valid = 1'b0;
                    wr_addr  = '0;
                    new_mask = lk_vec;
                end
            end
            OP_NONE: begin
                wr_en = 1'b0;
            end
        endcase
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        paddr_d = paddr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    pend_d  = new_mask;
                    paddr_d = new_addr;
                    if (new_mask != '0) state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                pend_d = pend_q & ~pk_onehot;
                if ((pend_q & ~pk_onehot) == '0) state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_q      <= '0;
            paddr_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
        end else begin
            state_q     <= state_d;
            pend_q      <= pend_d;
            paddr_q     <= paddr_d;
            rsp_valid_q <= accept;
            rsp_hit_q   <= accept && lk_hit && (op != OP_NONE);
        end
    end

    // Outputs.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q == ST_DRAIN);
        inv_valid = (state_q == ST_DRAIN) && pk_any;
        inv_core  = pk_idx;
        inv_addr  = paddr_q;
        rsp_valid = rsp_valid_q;
        rsp_hit   = rsp_hit_q;
    end
endmodule

// File: rtl/sdir_ctrl_chk.sv
module sdir_ctrl_chk #(
    parameter int NUM_CORES = 8,
    parameter int LINE_AW   = 26
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic                         rsp_valid,
    input logic                         inv_valid,
    input logic [$clog2(NUM_CORES)-1:0] inv_core,
    input logic [LINE_AW-1:0]           inv_addr,
    input logic                         busy
);
    // R6
    inv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && $past(inv_valid)) |-> (inv_core > $past(inv_core)));

    // R6
    inv_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && $past(inv_valid)) |-> (inv_addr == $past(inv_addr)));

    // R7
    inv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> busy);

    // R7
    held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !rsp_valid);

    // R2
    rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rsp_valid)) |-> $past(req_ready, 2));
endmodule

bind sdir_ctrl sdir_ctrl_chk #(
    .NUM_CORES(NUM_CORES),
    .LINE_AW  (LINE_AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .inv_valid(inv_valid),
    .inv_core (inv_core),
    .inv_addr (inv_addr),
    .busy     (busy)
);

// File: tb/sim_sdir_ctrl.sv
`timescale 1ns/1ps
module sim_sdir_ctrl;
    localparam int NC = 8;
    localparam int AW = 26;
    localparam logic [1:0] LD = 2'b00, ST = 2'b01, EV = 2'b10, NOP = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [2:0]    req_core = '0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid, rsp_hit, inv_valid, busy;
    logic [2:0]    inv_core;
    logic [AW-1:0] inv_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdir_ctrl #(.NUM_CORES(NC), .NUM_ENTRIES(4), .LINE_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_core(req_core), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .inv_valid(inv_valid),
        .inv_core(inv_core), .inv_addr(inv_addr), .busy(busy)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Issue one request, then verify response, invalidation sequence and release.
    task automatic run(string tag, logic [1:0] op, logic [2:0] core, logic [AW-1:0] addr,
                       logic exp_hit, logic [NC-1:0] exp_mask, logic [AW-1:0] exp_line);
        logic [2:0] seq [16];
        int n = 0;
        int bad_side = 0;
        int bad_order = 0;
        int k = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_core = core; req_addr = addr;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R2 rsp_valid"}, 32'(rsp_valid), 1);
        check({tag, " R2 rsp_hit"}, 32'(rsp_hit), 32'(exp_hit));
        while (inv_valid && n < 16) begin
            seq[n] = inv_core;
            if (inv_addr !== exp_line || !busy || req_ready) bad_side++;
            n++;
            @(negedge clk);
        end
        for (int c = 0; c < NC; c++) begin
            if (exp_mask[c]) begin
                if (k >= n || seq[k] != 3'(c)) bad_order++;
                k++;
            end
        end
        check({tag, " R6 inv count"}, 32'(n), 32'($countones(exp_mask)));
        check({tag, " R6 inv order"}, 32'(bad_order), 0);
        check({tag, " R7 inv line and busy"}, 32'(bad_side), 0);
        check({tag, " R8 ready after"}, 32'({req_ready, busy}), 32'b10);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ready", 32'(req_ready), 1);
        check("R1 busy", 32'(busy), 0);
        check("R1 inv_valid", 32'(inv_valid), 0);
        run("R1 empty evict", EV, 3'd0, 26'h100, 1'b0, 8'h00, '0);
    endtask

    task automatic t_loads();
        run("R2 load miss", LD, 3'd2, 26'h111, 1'b0, 8'h00, '0);
        run("R2 load hit c5", LD, 3'd5, 26'h111, 1'b1, 8'h00, '0);
        run("R2 load hit c0", LD, 3'd0, 26'h111, 1'b1, 8'h00, '0);
        run("R5 evict sharers", EV, 3'd7, 26'h111, 1'b1, 8'b0010_0101, 26'h111);
        run("R5 evict again", EV, 3'd7, 26'h111, 1'b0, 8'h00, '0);
    endtask

    task automatic t_store();
        run("R4 ld c1", LD, 3'd1, 26'h222, 1'b0, 8'h00, '0);
        run("R4 ld c3", LD, 3'd3, 26'h222, 1'b1, 8'h00, '0);
        run("R4 ld c6", LD, 3'd6, 26'h222, 1'b1, 8'h00, '0);
        run("R4 store c3", ST, 3'd3, 26'h222, 1'b1, 8'b0100_0010, 26'h222);
        run("R4 own bit kept", EV, 3'd0, 26'h222, 1'b1, 8'b0000_1000, 26'h222);
    endtask

    task automatic t_store_miss();
        run("R3 store miss", ST, 3'd4, 26'h333, 1'b0, 8'h00, '0);
        run("R3 no alloc", LD, 3'd4, 26'h333, 1'b0, 8'h00, '0);
        run("R3 store non-sharer", ST, 3'd7, 26'h333, 1'b1, 8'b0001_0000, 26'h333);
        run("R3 no bit set", EV, 3'd0, 26'h333, 1'b1, 8'h00, '0);
    endtask

    task automatic t_stall();
        int waits = 0;
        int bad_rsp = 0;
        for (int c = 0; c < NC; c++) run("R7 fill", LD, 3'(c), 26'h444, c != 0, 8'h00, '0);
        @(negedge clk);
        req_valid = 1'b1; req_op = EV; req_core = 3'd0; req_addr = 26'h444;
        @(posedge clk);
        @(negedge clk);
        req_op = LD; req_core = 3'd1; req_addr = 26'h555;
        check("R7 evict rsp", 32'({rsp_valid, rsp_hit}), 32'b11);
        while (!req_ready && waits < 20) begin
            if (waits > 0 && rsp_valid) bad_rsp++;
            if (!busy) bad_rsp++;
            waits++;
            @(negedge clk);
        end
        check("R7 held cycles", 32'(waits), 8);
        check("R7 no rsp while held", 32'(bad_rsp), 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 held req accepted", 32'({rsp_valid, rsp_hit}), 32'b10);
        run("R7 held load recorded", EV, 3'd0, 26'h555, 1'b1, 8'b0000_0010, 26'h555);
    endtask

    task automatic t_replace();
        run("R9 fill0", LD, 3'd0, 26'h600, 1'b0, 8'h00, '0);
        run("R9 fill1", LD, 3'd1, 26'h601, 1'b0, 8'h00, '0);
        run("R9 fill2", LD, 3'd2, 26'h602, 1'b0, 8'h00, '0);
        run("R9 fill3", LD, 3'd3, 26'h603, 1'b0, 8'h00, '0);
        run("R9 share0", LD, 3'd5, 26'h600, 1'b1, 8'h00, '0);
        run("R9 victim0", LD, 3'd6, 26'h604, 1'b0, 8'b0010_0001, 26'h600);
        run("R9 victim1", LD, 3'd7, 26'h605, 1'b0, 8'b0000_0010, 26'h601);
        run("R9 new line kept", EV, 3'd0, 26'h604, 1'b1, 8'b0100_0000, 26'h604);
        run("R9 victim gone", EV, 3'd0, 26'h600, 1'b0, 8'h00, '0);
    endtask

    task automatic t_nop();
        run("R10 ld", LD, 3'd2, 26'h700, 1'b0, 8'h00, '0);
        run("R10 op11", NOP, 3'd3, 26'h700, 1'b0, 8'h00, '0);
        run("R10 mask unchanged", EV, 3'd0, 26'h700, 1'b1, 8'b0000_0100, 26'h700);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_loads();
        t_store();
        t_store_miss();
        t_stall();
        t_replace();
        t_nop();
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule